// File: doc/BRIEF.md
# Power Island Sequencing Controller

This block brings a switchable logic island up and down in a fixed order. It drives the power-switch enable, a 2-bit inrush-current limit, and release lines for electrical and functional isolation. It also starts the island's memory repair and watches the power-good and repair-done responses that come back. A power-up closes the switch at the lowest inrush level. If power-good does not arrive within a bounded wait, the level steps up, up to the highest level. Electrical isolation is then released and memory repair is run. Functional isolation is released only when repair has completed. A power-down reverses the isolation and then opens the switch.

Requests arrive as single-cycle pulses on dedicated inputs. They can also come as keyed register writes, which are accepted only when the top byte of the write word carries the key. A status word shows the island control state, with the inrush level in a fixed field. When a step fails, the block undoes only the stages it had already taken. It then reports an error together with the completion pulse.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset the switch enable is 0, the inrush level is 0, both isolation releases are 0, repair start is 0, and busy, done and error are 0.
- R2: A register write is accepted only when write-data bits 31:24 equal 0x5A. An accepted write with bit 0 set requests power-up, and one with bit 1 set requests power-down. A write with any other key starts nothing and changes no output.
- R3: A power-up request that arrives while the switch is already enabled gives a done pulse in the next cycle. Busy stays low and no control output changes.
- R4: A power-up closes the switch at inrush level 0. For every PG_WAIT cycles without power-good, the level goes up by one, and it stays at the level where power-good arrived.
- R5: If power-good is still low when the wait at level 3 expires, the switch enable and the inrush level return to 0, and done is pulsed with error set.
- R6: Once power-good is seen, electrical isolation is released first. Repair start is raised in a later cycle, and while repair start is high the electrical release is high.
- R7: If repair-done does not arrive within REP_WAIT cycles, repair start drops and electrical isolation is re-asserted. In the following cycle the switch enable and the inrush level are cleared, and done is pulsed with error set.
- R8: Functional isolation is released only as the final step of a successful power-up. The functional release is never high without the electrical release, and the electrical release is never high without the switch enable.
- R9: A power-down drops the functional release in the cycle after the request, the electrical release in the next cycle, and the switch enable together with the inrush level in the cycle after that, with done in that same cycle.
- R10: Busy is high while a sequence runs, and requests that arrive during that time are ignored. Done is a single-cycle pulse with busy low. Error holds until the next accepted request. A power-up request takes priority over a simultaneous power-down request.
- R11: The status word reports the switch enable in bit 0, power-good in bit 1, the electrical release in bit 2, repair start in bit 3, repair-done in bit 4, the functional release in bit 5, busy in bit 6, error in bit 7, and the inrush level in bits 14:13. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_req_i | input | 1 | Power-up request pulse |
| off_req_i | input | 1 | Power-down request pulse |
| pwr_good_i | input | 1 | Island supply is good |
| repair_done_i | input | 1 | Memory repair has finished |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Write word, key in bits 31:24 |
| reg_rdata_o | output | 32 | Status word |
| sw_en_o | output | 1 | Power-switch enable |
| inrush_o | output | 2 | Inrush-current limit level |
| elec_rel_o | output | 1 | Electrical isolation released |
| func_rel_o | output | 1 | Functional isolation released |
| repair_start_o | output | 1 | Memory repair start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, one cycle |
| err_o | output | 1 | Last sequence failed |

## Verification
The bench models the supply so that power-good appears only once a chosen inrush level is reached, or never. It models repair-done with a chosen delay, or never. These two models cover success at every level, a timeout after the last level, and a repair timeout. A design that reset the level between steps, or that stopped before level 3, would finish at the wrong level or flag its error early. A design that skipped the unwind would leave the switch closed after a failure. The bench also sends a power-down while a power-up is still running, sends a write with a wrong key, and sends a power-up to an island that is already on. A design that let a late request through would end up powered down. One that honoured a bad key, or restarted an island that was already on, would raise busy. The power-down order is checked cycle by cycle, so releases that were swapped or merged into one cycle are caught.

// File: rtl/pis_pkg.sv
package pis_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PWAIT, S_REP_GO, S_REPAIR, S_UNDO_SW, S_OFF_ELEC, S_OFF_SW
  } pis_state_e;
  localparam logic [7:0] WR_KEY     = 8'h5A;
  localparam int         INRUSH_LSB = 13;
  localparam int         INRUSH_W   = 2;
endpackage

// File: rtl/pis_key_gate.sv
module pis_key_gate
  import pis_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          on_o,
  output logic          off_o
);
  logic key_ok;
  assign key_ok = we_i && (wdata_i[DW-1 -: 8] == WR_KEY);
  assign on_o   = key_ok && wdata_i[0];
  assign off_o  = key_ok && wdata_i[1];
endmodule

// File: rtl/pis_wait_timer.sv
module pis_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [CW-1:0] last_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;
  assign hit_o = (cnt_q == last_i);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (!hit_o)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pis_seq_fsm.sv
module pis_seq_fsm
  import pis_pkg::*;
#(
  parameter int PG_WAIT  = 150,
  parameter int REP_WAIT = 50,
  parameter int CW       = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                on_i,
  input  logic                off_i,
  input  logic                pg_i,
  input  logic                rdone_i,
  input  logic                hit_i,
  output logic                restart_o,
  output logic [CW-1:0]       last_o,
  output logic                sw_o,
  output logic [INRUSH_W-1:0] lvl_o,
  output logic                elec_o,
  output logic                func_o,
  output logic                rep_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o
);
  localparam logic [INRUSH_W-1:0] LVL_TOP = '1;

  pis_state_e state_q;

  assign busy_o    = (state_q != S_IDLE);
  assign restart_o = !(state_q inside {S_PWAIT, S_REPAIR}) || (state_q == S_PWAIT && hit_i);
  assign last_o    = (state_q == S_REPAIR) ? CW'(REP_WAIT - 1) : CW'(PG_WAIT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sw_o    <= 1'b0;
      lvl_o   <= '0;
      elec_o  <= 1'b0;
      func_o  <= 1'b0;
      rep_o   <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (on_i) begin
            err_o <= 1'b0;
            if (sw_o) done_o <= 1'b1;   // already up: no change
            else begin
              sw_o    <= 1'b1;
              lvl_o   <= '0;
              state_q <= S_PWAIT;
            end
          end else if (off_i) begin
            err_o   <= 1'b0;
            func_o  <= 1'b0;
            state_q <= S_OFF_ELEC;
          end
        end
        S_PWAIT: begin
          if (pg_i) begin
            elec_o  <= 1'b1;
            state_q <= S_REP_GO;
          end else if (hit_i) begin
            if (lvl_o == LVL_TOP) begin
              sw_o    <= 1'b0;
              lvl_o   <= '0;
              err_o   <= 1'b1;
              done_o  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              lvl_o <= lvl_o + 1'b1;
            end
          end
        end
        S_REP_GO: begin
          rep_o   <= 1'b1;
          state_q <= S_REPAIR;
        end
        S_REPAIR: begin
          if (rdone_i) begin
            rep_o   <= 1'b0;
            func_o  <= 1'b1;
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else if (hit_i) begin
            rep_o   <= 1'b0;
            elec_o  <= 1'b0;
            state_q <= S_UNDO_SW;
          end
        end
        S_UNDO_SW: begin
          sw_o    <= 1'b0;
          lvl_o   <= '0;
          err_o   <= 1'b1;
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
        S_OFF_ELEC: begin
          elec_o  <= 1'b0;
          state_q <= S_OFF_SW;
        end
        S_OFF_SW: begin
          sw_o    <= 1'b0;
          lvl_o   <= '0;
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq
  import pis_pkg::*;
#(
  parameter int PG_WAIT  = 150,
  parameter int REP_WAIT = 50
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        on_req_i,
  input  logic        off_req_i,
  input  logic        pwr_good_i,
  input  logic        repair_done_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sw_en_o,
  output logic [1:0]  inrush_o,
  output logic        elec_rel_o,
  output logic        func_rel_o,
  output logic        repair_start_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int MAXW = (PG_WAIT > REP_WAIT) ? PG_WAIT : REP_WAIT;
  localparam int CW   = $clog2(MAXW + 1);

  logic          wr_on, wr_off, hit, restart;
  logic [CW-1:0] last;

  pis_key_gate #(.DW(32)) i_key (
    .we_i(reg_we_i), .wdata_i(reg_wdata_i), .on_o(wr_on), .off_o(wr_off)
  );

  pis_wait_timer #(.CW(CW)) i_tmr (
    .clk_i, .rst_ni, .restart_i(restart), .last_i(last), .hit_o(hit)
  );

  pis_seq_fsm #(.PG_WAIT(PG_WAIT), .REP_WAIT(REP_WAIT), .CW(CW)) i_fsm (
    .clk_i, .rst_ni,
    .on_i(on_req_i | wr_on), .off_i(off_req_i | wr_off),
    .pg_i(pwr_good_i), .rdone_i(repair_done_i),
    .hit_i(hit), .restart_o(restart), .last_o(last),
    .sw_o(sw_en_o), .lvl_o(inrush_o), .elec_o(elec_rel_o), .func_o(func_rel_o),
    .rep_o(repair_start_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always_comb begin
    reg_rdata_o    = '0;
    reg_rdata_o[0] = sw_en_o;
    reg_rdata_o[1] = pwr_good_i;
    reg_rdata_o[2] = elec_rel_o;
    reg_rdata_o[3] = repair_start_o;
    reg_rdata_o[4] = repair_done_i;
    reg_rdata_o[5] = func_rel_o;
    reg_rdata_o[6] = busy_o;
    reg_rdata_o[7] = err_o;
    reg_rdata_o[INRUSH_LSB +: INRUSH_W] = inrush_o;
  end
endmodule

// File: rtl/pis_island_chk.sv
module pis_island_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       on_req_i,
  input logic       off_req_i,
  input logic       reg_we_i,
  input logic [7:0] key_i,
  input logic       sw_en_o,
  input logic [1:0] inrush_o,
  input logic       elec_rel_o,
  input logic       func_rel_o,
  input logic       repair_start_o,
  input logic       busy_o,
  input logic       done_o
);
  // R8
  func_needs_elec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_rel_o |-> elec_rel_o);
  // R8
  elec_needs_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elec_rel_o |-> sw_en_o);
  // R6
  repair_after_elec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repair_start_o |-> elec_rel_o);
  // R4
  inrush_needs_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inrush_o != 2'd0) |-> sw_en_o);
  // R9
  sw_open_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_en_o) |-> (!elec_rel_o && !func_rel_o));
  // R9
  elec_after_func_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(elec_rel_o) |-> !func_rel_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R2
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && key_i != 8'h5A && !on_req_i && !off_req_i && !busy_o) |=> !busy_o);
  // R3
  already_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_req_i && sw_en_o && !busy_o) |=> (!busy_o && done_o));
endmodule

bind pwr_island_seq pis_island_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .on_req_i(on_req_i), .off_req_i(off_req_i),
  .reg_we_i(reg_we_i), .key_i(reg_wdata_i[31:24]), .sw_en_o(sw_en_o),
  .inrush_o(inrush_o), .elec_rel_o(elec_rel_o), .func_rel_o(func_rel_o),
  .repair_start_o(repair_start_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_pwr_island_seq.sv
`timescale 1ns/1ps
module test_pwr_island_seq;
  localparam int PG  = 20;
  localparam int REP = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic on_req = 0, off_req = 0, pg = 0, rdone = 0, we = 0;
  logic [31:0] wdata = '0, rdata;
  logic sw, elec, func, rep, busy, done, err;
  logic [1:0] inr;

  int total = 0, bad = 0, need = 4, rdel = 1000, rc = 0, ord_bad = 0;
  bit busy_seen = 0, finished = 0;

  always #10 clk = ~clk;

  pwr_island_seq #(.PG_WAIT(PG), .REP_WAIT(REP)) i_pwr_island_seq (
    .clk_i(clk), .rst_ni(rst_n), .on_req_i(on_req), .off_req_i(off_req),
    .pwr_good_i(pg), .repair_done_i(rdone), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sw_en_o(sw), .inrush_o(inr), .elec_rel_o(elec),
    .func_rel_o(func), .repair_start_o(rep), .busy_o(busy), .done_o(done), .err_o(err)
  );

  // supply and repair models, plus ordering monitor
  always @(negedge clk) begin
    int rn;
    pg <= sw && (int'(inr) >= need);
    rn = rep ? rc + 1 : 0;
    rc = rn;
    rdone <= rep && (rn >= rdel);
    if (busy) busy_seen = 1;
    if ((func && !elec) || (elec && !sw) || (rep && !elec)) ord_bad++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {err, sw, inrush, elec, func}
  function automatic logic [5:0] exp_on(int n, int d);
    if (n > 3)       return 6'b100000;
    if (d >= REP - 1) return 6'b100000;
    return {1'b0, 1'b1, 2'(n), 1'b1, 1'b1};
  endfunction

  function automatic logic [5:0] st();
    return {rdata[7], rdata[0], rdata[14:13], rdata[2], rdata[5]};
  endfunction

  task automatic pulse(bit use_reg, bit is_on);
    @(negedge clk);
    if (use_reg) begin we = 1; wdata = {8'h5A, 22'd0, !is_on, is_on}; end
    else if (is_on) on_req = 1;
    else off_req = 1;
    @(negedge clk);
    we = 0; wdata = '0; on_req = 0; off_req = 0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 500) begin @(negedge clk); cyc++; end
  endtask

  task automatic power_up(bit use_reg, int n, int d, string req);
    int cyc;
    need = n; rdel = d;
    pulse(use_reg, 1);
    wait_done(cyc);
    check({req, " done seen"}, done, 1'b1);
    check(req, st(), exp_on(n, d));
    @(negedge clk);
    check("R10 done one cycle", done, 1'b0);
  endtask

  initial begin
    int cyc;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 status after reset", rdata, 32'h0);
    check("R1 ports after reset", {sw, inr, elec, func, rep, busy, done, err}, 9'd0);

    power_up(0, 0, 2, "R4 R6 R8 level0 success");
    check("R11 inrush field", rdata[14:13], inr);
    check("R11 port mirror", {rdata[0], rdata[2], rdata[5], rdata[6]}, {sw, elec, func, busy});

    busy_seen = 0;
    pulse(0, 1);
    check("R3 already-on done", done, 1'b1);
    check("R3 no change", st(), 6'b010011);
    check("R3 busy stays low", busy_seen, 1'b0);

    // power-down via keyed write, cycle by cycle
    pulse(1, 0);
    check("R9 func drops first", {func, elec, sw, busy}, 4'b0111);
    @(negedge clk);
    check("R9 elec drops second", {func, elec, sw, busy}, 4'b0011);
    @(negedge clk);
    check("R9 switch opens last", {func, elec, sw, inr, done, busy}, 7'b0000010);

    busy_seen = 0;
    @(negedge clk);
    we = 1; wdata = {8'hA5, 24'h000001};
    @(negedge clk);
    we = 0; wdata = '0;
    repeat (4) @(negedge clk);
    check("R2 bad key ignored", {busy_seen, sw, func, done}, 4'b0000);

    power_up(0, 4, 2, "R5 all levels time out");
    power_up(1, 2, 3, "R4 R2 success at level 2");
    pulse(0, 0); wait_done(cyc);
    power_up(0, 1, 1000, "R7 repair timeout unwinds");
    check("R7 repair start low", rep, 1'b0);

    // R10: off request during power-up is ignored; err clears on new request
    need = 3; rdel = 2;
    pulse(0, 1);
    check("R10 busy during sequence", busy, 1'b1);
    check("R10 err cleared by request", err, 1'b0);
    repeat (3) @(negedge clk);
    pulse(0, 0);
    wait_done(cyc);
    check("R10 off ignored while busy", st(), exp_on(3, 2));

    for (int i = 0; i < 30; i++) begin
      if (sw) begin pulse($urandom % 2, 0); wait_done(cyc); @(negedge clk); end
      power_up($urandom % 2, $urandom % 5, ($urandom % 4 == 0) ? 1000 : 1 + $urandom % 5,
               "R4 R5 R6 R7 R8 random");
    end
    check("R6 R8 ordering monitor", ord_bad, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule